// File: doc/BRIEF.md
# Strobed Latched Byte Port

This block is an eight-bit parallel port built around a bank of transparent data latches whose contents are driven onto a three-state output bus. A mode pin picks how the port is used. As an output port (mode high), the decoded device select opens the latches, and the output bus is driven all the time. As an input port (mode low), an external strobe opens the latches, and the bus is driven only while the device is selected.

A service-request flop records a falling strobe edge so that a host can be interrupted. The request is cleared whenever the device is selected. The active-low interrupt shows a pending request only while the device is not selected. The latches also have an active-low clear, which gives way to an open latch.

The port is part of a synchronous chip. Every pin is sampled on `clk`, and the latch state and service request are held in flops. Transparency therefore appears one clock after the sample. The output enable and the interrupt are combinational from the current pins and the stored state.

Top module: `sport_io_port`

## Requirements
- R1: The device counts as selected only when `dsel_n` is low and `dsel` is high. Any other combination leaves it unselected.
- R2: With `mode` high, `pad_oe` is high whatever the select, and the latch gate equals the select. The strobe has no effect on the latched data in this mode.
- R3: With `mode` low, the latch gate equals `stb`, and `pad_oe` is high only while the device is selected.
- R4: When the latch gate is high at a rising clock edge, the latched value becomes `din`, and that value is visible from that edge onward.
- R5: When the gate is low and `clr_n` is low at an edge, the latched value becomes zero. When the gate is high, a low `clr_n` is ignored and `din` is taken.
- R6: When the gate is low and `clr_n` is high, the latched value holds.
- R7: While `pad_oe` is high, `dout` carries the latched value. While `pad_oe` is low, `dout` is high-impedance.
- R8: A falling strobe sets the service request at that edge, provided the device is not selected. A falling strobe is `stb` sampled high at one edge and low at the next.
- R9: A selected device clears the service request at each edge. The clear wins over a falling strobe at the same edge.
- R10: `int_n` is low exactly when a request is pending and the device is not selected. It returns high in the same cycle that the select is applied.
- R11: While `rst_n` is low, the latches are zero, the request is clear and the strobe history is low, so `int_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | W | Data into the latches |
| dsel_n | input | 1 | Select term, active low |
| dsel | input | 1 | Select term, active high |
| mode | input | 1 | 1 = output port, 0 = input (strobed) port |
| stb | input | 1 | Strobe: latch gate in input mode, request source |
| clr_n | input | 1 | Active-low latch clear |
| dout | output | W | Three-state data bus |
| pad_oe | output | 1 | High while `dout` is driven |
| int_n | output | 1 | Active-low interrupt |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the latch gate and the clear. The bench drives `clr_n` low while the gate is high and again while it is low, in both modes, and expects `din` in the first case and zero in the second. The second pair is the falling-strobe set and the select clear of the service request. The bench drops `stb` in the same cycle as it selects the device, then deselects and expects `int_n` to stay high because the request never set.

// File: rtl/sport_pkg.sv
package sport_pkg;

  // select decode: one active-low term, one active-high term
  function automatic logic dev_selected(input logic ds_n, input logic ds);
    return (!ds_n) && ds;
  endfunction

  // latch gate source picked by mode
  function automatic logic latch_gate(input logic mode, input logic sel, input logic stb);
    return mode ? sel : stb;
  endfunction

  // output drive: always in output mode, on select otherwise
  function automatic logic drive_enable(input logic mode, input logic sel);
    return mode || sel;
  endfunction

  // falling strobe between two samples
  function automatic logic strobe_fell(input logic prev, input logic now);
    return prev && !now;
  endfunction

  // next service-request state: select clear beats the set
  function automatic logic srq_next(input logic cur, input logic sel, input logic fall);
    if (sel) return 1'b0;
    if (fall) return 1'b1;
    return cur;
  endfunction

  // interrupt, active low
  function automatic logic irq_level_n(input logic srq, input logic sel);
    return !(srq && !sel);
  endfunction

endpackage

// File: rtl/sport_decode.sv
module sport_decode
  import sport_pkg::*;
(
  input  logic dsel_n,
  input  logic dsel,
  input  logic mode,
  input  logic stb,
  output logic sel,
  output logic gate,
  output logic oe
);

  always_comb begin
    sel  = dev_selected(dsel_n, dsel);
    gate = latch_gate(mode, sel, stb);
    oe   = drive_enable(mode, sel);
  end

endmodule

// File: rtl/sport_latch.sv
module sport_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // one cell per bit: gate open takes data, closed gate honours clear
  for (genvar b = 0; b < W; b++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[b] <= 1'b0;
      else if (gate)   q[b] <= d[b];
      else if (!clr_n) q[b] <= 1'b0;
    end
  end

endmodule

// File: rtl/sport_srq.sv
module sport_srq
  import sport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic sel,
  output logic stb_fall,
  output logic srq,
  output logic int_n
);

  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign stb_fall = strobe_fell(stb_q, stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srq <= 1'b0;
    else        srq <= srq_next(srq, sel, stb_fall);
  end

  assign int_n = irq_level_n(srq, sel);

endmodule

// File: rtl/sport_io_port.sv
module sport_io_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         dsel_n,
  input  logic         dsel,
  input  logic         mode,
  input  logic         stb,
  input  logic         clr_n,
  output logic [W-1:0] dout,
  output logic         pad_oe,
  output logic         int_n
);

  logic         sel;
  logic         latch_clk;
  logic         oe;
  logic         stb_fall;
  logic         srq;
  logic [W-1:0] q_lat;

  sport_decode u_dec (
    .dsel_n (dsel_n),
    .dsel   (dsel),
    .mode   (mode),
    .stb    (stb),
    .sel    (sel),
    .gate   (latch_clk),
    .oe     (oe)
  );

  sport_latch #(.W(W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (latch_clk),
    .clr_n (clr_n),
    .d     (din),
    .q     (q_lat)
  );

  sport_srq u_srq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .sel      (sel),
    .stb_fall (stb_fall),
    .srq      (srq),
    .int_n    (int_n)
  );

  assign pad_oe = oe;
  assign dout   = oe ? q_lat : {W{1'bz}};

endmodule

// File: rtl/sport_io_port_chk.sv
module sport_io_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] din,
  input logic         mode,
  input logic         clr_n,
  input logic         sel,
  input logic         latch_clk,
  input logic         stb_fall,
  input logic         srq,
  input logic [W-1:0] q_lat,
  input logic         pad_oe,
  input logic         int_n
);

  a_r2_drive_in_output_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> pad_oe);

  a_r3_float_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !sel) |-> !pad_oe);

  a_r4_open_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clk |=> (q_lat == $past(din)));

  a_r5_clear_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_clk && !clr_n) |=> (q_lat == '0));

  a_r6_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_clk && clr_n) |=> $stable(q_lat));

  a_r8_fall_sets_request: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && !sel) |=> srq);

  a_r9_select_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> !srq);

  a_r10_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> (srq && !sel));

endmodule

bind sport_io_port sport_io_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .mode      (mode),
  .clr_n     (clr_n),
  .sel       (sel),
  .latch_clk (latch_clk),
  .stb_fall  (stb_fall),
  .srq       (srq),
  .q_lat     (q_lat),
  .pad_oe    (pad_oe),
  .int_n     (int_n)
);

// File: tb/sport_io_port_bench.sv
`timescale 1ns/1ps
module sport_io_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic       dsel_n = 1'b1, dsel = 1'b0, mode = 1'b1, stb = 1'b0, clr_n = 1'b1;
  wire  [7:0] dout;
  wire        pad_oe, int_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sport_io_port #(.W(8)) u_sport_io_port (
    .clk(clk), .rst_n(rst_n), .din(din), .dsel_n(dsel_n), .dsel(dsel),
    .mode(mode), .stb(stb), .clr_n(clr_n), .dout(dout), .pad_oe(pad_oe), .int_n(int_n)
  );

  typedef struct packed {
    logic       ds_n;
    logic       ds;
    logic       md;
    logic       sb;
    logic       cl_n;
    logic [7:0] di;
    logic       e_oe;
    logic [7:0] e_q;
    logic       e_int_n;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b0,1'b1,1'b0,1'b1,8'hA5, 1'b1,8'h00,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,1'b1,8'hA5, 1'b1,8'hA5,1'b1},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,8'h3C, 1'b1,8'hA5,1'b1},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,8'h3C, 1'b1,8'h00,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h5A, 1'b1,8'h5A,1'b1},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,8'hFF, 1'b1,8'h5A,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,8'hC3, 1'b0,8'hC3,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h11, 1'b0,8'hC3,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'h22, 1'b1,8'hC3,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h77, 1'b0,8'h77,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h77, 1'b0,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'h99, 1'b1,8'h00,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,8'h99, 1'b0,8'h00,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,8'h44, 1'b1,8'h00,1'b1}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 2, 5: return "R6 R2";
      1:       return "R4 R2";
      3:       return "R5";
      4:       return "R5 R2";
      6:       return "R3 R4";
      7:       return "R8 R10";
      8:       return "R9 R10 R7";
      9:       return "R5 R3";
      10:      return "R5 R8";
      11:      return "R9 R7";
      12, 13:  return "R1";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic ds_n, ds, md, sb, cl_n, input logic [7:0] di);
    @(negedge clk);
    dsel_n = ds_n; dsel = ds; mode = md; stb = sb; clr_n = cl_n; din = di;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset state, output mode so the bus is driven
    repeat (3) @(posedge clk);
    #1;
    check("R11 dout", dout, 8'h00);
    check("R11 int_n", {7'd0, int_n}, 8'd1);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].ds_n, VT[i].ds, VT[i].md, VT[i].sb, VT[i].cl_n, VT[i].di);
      check({vtag(i), " oe"}, {7'd0, pad_oe}, {7'd0, VT[i].e_oe});
      if (VT[i].e_oe) check({vtag(i), " dout"}, dout, VT[i].e_q);
      check({vtag(i), " int_n"}, {7'd0, int_n}, {7'd0, VT[i].e_int_n});
    end

    // R2: strobe has no effect on data in output mode
    apply(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hE7);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hE7);
    check("R2 strobe ignored", dout, 8'h00);
    check("R8 fall in output mode", {7'd0, int_n}, 8'd0);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h6B);
    check("R10 select lifts int", {7'd0, int_n}, 8'd1);

    // R9: fall at the same edge as select does not set the request
    apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h12);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h34);
    check("R9 clear wins dout", dout, 8'h12);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h34);
    check("R9 clear wins int_n", {7'd0, int_n}, 8'd1);
    check("R7 no drive", {7'd0, pad_oe}, 8'd0);

    // R11: reset in the middle drops a pending request
    apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h56);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h56);
    check("R8 pending", {7'd0, int_n}, 8'd0);
    @(negedge clk) rst_n = 1'b0; mode = 1'b1;
    #1;
    check("R11 mid reset int_n", {7'd0, int_n}, 8'd1);
    check("R11 mid reset dout", dout, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule